// File: doc/BRIEF.md
# Indirect Extended Register Access Controller

A management host can address only 32 registers directly. This block gives it access to a larger extended register space through two of those registers. One is a control register that holds a function code and a device number. The other is a shared window register. Depending on the function code, the window either loads an internal extended-address pointer or carries data to and from the extended entry that the pointer selects.

Three data modes set how the pointer moves after each access. It can stay put, advance after every read and write, or advance after writes only. This lets the host stream blocks of extended registers without reloading the pointer. Window accesses take effect only when the device number 0x1F has been written. The extended space is modelled as an internal array of 32 words of 16 bits, cleared by reset.

Top module: `xreg_indirect`

## Requirements
- R1: The control register is at management address 0x0D and the window is at 0x0E. A write to any other address changes nothing, and a read of any other address returns 0.
- R2: Control bits [15:14] hold the function code and bits [4:0] hold the device number. Both reset to 0.
- R3: With function code 0 (pointer mode), a window write loads the pointer from write data bits [4:0]. A window read returns the pointer, zero-extended to 16 bits.
- R4: With function code 1, a window read or write acts on the entry selected by the pointer, and the pointer is left unchanged.
- R5: With function code 2, the pointer advances by one after every window read and every window write, and wraps from 31 to 0.
- R6: With function code 3, the pointer advances by one after a window write. A window read leaves it unchanged.
- R7: A read of the control register returns 0, so the function and device fields are write-only and bits [13:5] read as zero.
- R8: While the device number is not 0x1F, a window access is ignored. A read returns 0, and neither the pointer nor the array changes. After reset the device number is 0, so windows are closed until 0x1F is written.
- R9: Read data is registered. It appears in the cycle after the read strobe and holds until the next read. A pointer step takes effect on the edge that completes the access, so a back-to-back access on the next cycle uses the new pointer.
- R10: When read and write strobes are both high in one cycle, only the write is performed and the read data is left unchanged.
- R11: Reset clears the pointer, every array entry and the read data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_wr_en | input | 1 | Register write strobe, one cycle per write |
| mgmt_rd_en | input | 1 | Register read strobe, one cycle per read |
| mgmt_addr | input | 5 | Management register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Registered read data |

## Verification
Every effect of a strobe is due on the next rising edge. A pointer load, a pointer step or an array write made by one access is visible to an access issued in the following cycle. Read data appears one edge after the read strobe. The bench applies one operation per cycle at the falling edge and updates its behavioural model for that edge. At the next falling edge it compares the read data with the model, so every cycle is checked, including back-to-back streaming reads and the held value after non-read cycles.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  localparam logic [4:0] CTRL_REG_ADDR = 5'h0D;
  localparam logic [4:0] WIN_REG_ADDR  = 5'h0E;
  localparam logic [4:0] OWN_DEV_ID    = 5'h1F;

  typedef enum logic [1:0] {
    FN_PTR        = 2'd0,
    FN_DATA_HOLD  = 2'd1,
    FN_DATA_INCRW = 2'd2,
    FN_DATA_INCWR = 2'd3
  } xfn_e;
endpackage

// File: rtl/xreg_ctrl.sv
module xreg_ctrl
  import xreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] fn_in,
  input  logic [4:0] dev_in,
  output xfn_e       fn_q,
  output logic       dev_ok
);
  logic [4:0] dev_q;
  xfn_e       fn_d;
  logic [4:0] dev_d;

  always_comb begin
    fn_d  = fn_q;
    dev_d = dev_q;
    if (wr_en) begin
      fn_d  = xfn_e'(fn_in);
      dev_d = dev_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q  <= FN_PTR;
      dev_q <= '0;
    end else if (wr_en) begin
      fn_q  <= fn_d;
      dev_q <= dev_d;
    end
  end

  assign dev_ok = (dev_q == OWN_DEV_ID);

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (fn_q == $past(fn_in)) && (dev_ok == ($past(dev_in) == OWN_DEV_ID))); // R2
endmodule

// File: rtl/xreg_ptr.sv
module xreg_ptr #(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)      ptr_d = load_val;
    else if (step) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ptr_q <= '0;
    else if (load || step)  ptr_q <= ptr_d;
  end

  AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(ptr_q)); // R4
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ptr_q == $past(load_val)); // R3
endmodule

// File: rtl/xreg_array.sv
module xreg_array #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = we && (idx == PTR_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[e] <= '0;
      else if (hit) mem_q[e] <= wdata;
    end
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/xreg_indirect.sv
module xreg_indirect
  import xreg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_wr_en,
  input  logic              mgmt_rd_en,
  input  logic [4:0]        mgmt_addr,
  input  logic [DATA_W-1:0] mgmt_wdata,
  output logic [DATA_W-1:0] mgmt_rdata
);
  xfn_e              fn_q;
  logic              dev_ok;
  logic              rd_eff, ctrl_wr, win_wr, win_rd, data_mode;
  logic              ptr_load, ptr_step, arr_we;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] rdata_d;

  assign rd_eff    = mgmt_rd_en && !mgmt_wr_en;
  assign ctrl_wr   = mgmt_wr_en && (mgmt_addr == CTRL_REG_ADDR);
  assign win_wr    = mgmt_wr_en && (mgmt_addr == WIN_REG_ADDR) && dev_ok;
  assign win_rd    = rd_eff && (mgmt_addr == WIN_REG_ADDR) && dev_ok;
  assign data_mode = (fn_q != FN_PTR);

  assign ptr_load = win_wr && !data_mode;
  assign arr_we   = win_wr && data_mode;
  assign ptr_step = (arr_we && (fn_q == FN_DATA_INCRW || fn_q == FN_DATA_INCWR))
                 || (win_rd && fn_q == FN_DATA_INCRW);

  xreg_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .fn_in  (mgmt_wdata[DATA_W-1 -: 2]),
    .dev_in (mgmt_wdata[4:0]),
    .fn_q   (fn_q),
    .dev_ok (dev_ok)
  );

  xreg_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (mgmt_wdata[PTR_W-1:0]),
    .step     (ptr_step),
    .ptr_q    (ptr_q)
  );

  xreg_array #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (arr_we),
    .idx   (ptr_q),
    .wdata (mgmt_wdata),
    .rdata (arr_rdata)
  );

  always_comb begin
    rdata_d = '0;
    if (win_rd) rdata_d = data_mode ? arr_rdata : {{(DATA_W-PTR_W){1'b0}}, ptr_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mgmt_rdata <= '0;
    else if (rd_eff) mgmt_rdata <= rdata_d;
  end

  AST_HOLD_MODE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_rd || win_wr) && fn_q == FN_DATA_HOLD) |=> $stable(ptr_q)); // R4
  AST_INCRW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_rd || win_wr) && fn_q == FN_DATA_INCRW) |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1)); // R5
  AST_INCWR_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && fn_q == FN_DATA_INCWR) |=> $stable(ptr_q)); // R6
  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_eff && mgmt_addr == CTRL_REG_ADDR) |=> mgmt_rdata == '0); // R7
  AST_FOREIGN_DEV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_addr == WIN_REG_ADDR && !dev_ok && (mgmt_wr_en || mgmt_rd_en))
      |=> $stable(ptr_q) && (mgmt_rdata == '0 || $past(mgmt_wr_en))); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wr_en && mgmt_rd_en) |=> $stable(mgmt_rdata)); // R10
endmodule

// File: tb/xreg_indirect_tb.sv
module xreg_indirect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int vectors = 0, errors = 0;
  bit done = 0;

  int          m_ptr = 0, m_fn = 0, m_dev = 0;
  logic [15:0] m_mem [32];
  logic [15:0] m_rdata = '0;

  always #4 clk = ~clk;

  xreg_indirect dut_i (
    .clk(clk), .rst_n(rst_n), .mgmt_wr_en(wr_en), .mgmt_rd_en(rd_en),
    .mgmt_addr(addr), .mgmt_wdata(wdata), .mgmt_rdata(rdata)
  );

  task automatic compare(input string req);
    vectors++;
    if (rdata !== m_rdata) begin
      errors++;
      $display("FAIL %s: rdata=%h expected=%h", req, rdata, m_rdata);
    end
  endtask

  task automatic model_edge(input bit w, input bit r, input int a, input logic [15:0] d);
    bit hit = (m_dev == 31);
    if (w) begin
      if (a == 13) begin m_fn = int'(d[15:14]); m_dev = int'(d[4:0]); end
      else if (a == 14 && hit) begin
        if (m_fn == 0) m_ptr = int'(d[4:0]);
        else begin
          m_mem[m_ptr] = d;
          if (m_fn >= 2) m_ptr = (m_ptr + 1) % 32;
        end
      end
    end else if (r) begin
      if (a == 14 && hit) begin
        if (m_fn == 0) m_rdata = 16'(m_ptr);
        else begin
          m_rdata = m_mem[m_ptr];
          if (m_fn == 2) m_ptr = (m_ptr + 1) % 32;
        end
      end else m_rdata = '0;
    end
  endtask

  // drive at falling edge, model the rising edge, compare at next falling edge
  task automatic op(input bit w, input bit r, input int a, input logic [15:0] d, input string req);
    wr_en = w; rd_en = r; addr = 5'(a); wdata = d;
    @(posedge clk);
    model_edge(w, r, a, d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    compare(req);
  endtask

  task automatic wr(input int a, input logic [15:0] d, input string req); op(1, 0, a, d, req); endtask
  task automatic rd(input int a, input string req); op(0, 1, a, '0, req); endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: rdata=%h expected=%h", rdata, m_rdata);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    compare("R11 reset read data");
    rst_n = 1'b1;
    @(negedge clk);
    rd(14, "R8 window closed after reset (R2 device 0)");
    wr(14, 16'h0007, "R8 ignored pointer write");
    wr(13, 16'h001F, "R2 control write pointer mode");
    rd(14, "R8 pointer untouched by ignored write / R11 pointer reset");
    wr(14, 16'hFFE3, "R3 pointer load low bits");
    rd(14, "R3 pointer readback");
    wr(13, 16'h401F, "R4 mode 1");
    wr(14, 16'hAAAA, "R4 write");
    wr(14, 16'hBBBB, "R4 overwrite same entry");
    rd(14, "R4 data read");
    rd(14, "R4 repeated read");
    wr(13, 16'h001F, "R4 back to pointer mode");
    rd(14, "R4 pointer unchanged");
    wr(14, 16'd30, "R3 load 30");
    wr(13, 16'h801F, "R5 mode 2");
    wr(14, 16'h1111, "R5 write 30");
    wr(14, 16'h2222, "R5 write 31");
    wr(14, 16'h3333, "R5 write wraps to 0");
    wr(13, 16'h001F, "R5 pointer mode");
    rd(14, "R5 pointer after wrap");
    wr(14, 16'd30, "R5 reload 30");
    wr(13, 16'h801F, "R5 mode 2 reads");
    rd(14, "R9 stream read 30");
    rd(14, "R9 back-to-back read 31");
    rd(14, "R5 read wrap to 0");
    wr(13, 16'h001F, "R6 pointer mode");
    wr(14, 16'd5, "R6 load 5");
    wr(13, 16'hC01F, "R6 mode 3");
    wr(14, 16'h5555, "R6 write advances");
    rd(14, "R6 read entry 6");
    rd(14, "R6 read again, no advance");
    wr(13, 16'h001F, "R6 pointer mode");
    rd(14, "R6 pointer is 6");
    op(0, 0, 0, '0, "R9 read data held on idle");
    rd(13, "R7 control reads zero");
    wr(3, 16'h1234, "R1 write elsewhere");
    rd(3, "R1 read elsewhere zero");
    wr(14, 16'd5, "R6 load 5 again");
    wr(13, 16'h401F, "R1 mode 1");
    rd(14, "R6 entry 5 kept (R1 no effect)");
    op(1, 1, 14, 16'h9999, "R10 write wins, rdata held");
    rd(14, "R10 write landed");
    wr(13, 16'h401E, "R8 foreign device");
    wr(14, 16'h0BAD, "R8 write ignored");
    rd(14, "R8 foreign read zero");
    wr(13, 16'h401F, "R8 own device again");
    rd(14, "R8 array unchanged");
    wr(13, 16'h7FFF, "R7 junk reserved bits");
    rd(13, "R7 still zero");
    rd(14, "R2 fields decoded from 15:14 and 4:0");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule